// File: doc/BRIEF.md
# LIN Break and Wakeup Detector

This block watches the already synchronised receive line of a LIN node and measures how long the line stays dominant (low). Time is counted in bit times, one count per pulse of a bit-tick strobe that some other part of the node derives. When the measured low time reaches a limit, the block raises a sticky break flag. The limit depends on the protocol state that the node's LIN state machine drives into the block.

The limits are as follows. A node that is asleep wakes after 4 bit times of dominant line. A slave that is waiting for a break needs 11 bit times. A slave that is already active needs 10 bit times. In master mode, and in any other state, the block never raises the flag. The flag stays set until the node's read strobe clears it. That strobe is pulsed when software reads the status word or the receive data register.

Top module: `lin_break_detect`

## Requirements
- R1: With `lin_state` = 2'b01 (sleep) and `master_mode` low, the flag sets once the line has been low for 4 bit ticks. At 3 ticks it stays clear.
- R2: With `lin_state` = 2'b10 (slave waiting for break), the flag sets at 11 ticks of low line. At 10 ticks it stays clear.
- R3: With `lin_state` = 2'b11 (slave active), the flag sets at 10 ticks of low line. At 9 ticks it stays clear.
- R4: When `master_mode` is high, or when `lin_state` = 2'b00, the flag never sets, however long the line stays low.
- R5: The flag is sticky. It holds until `rd_clr` is pulsed, and it reads 0 in the cycle after that pulse. If a new detection arrives in the same cycle as the pulse, the detection wins.
- R6: The low-time count returns to zero whenever `rx_sync` is high. Low periods that are separated by a high level never add up.
- R7: Within one low period the flag sets at most once. After it is cleared, further ticks on the same low period leave it clear. A new low period can set it again.
- R8: The low-time count saturates at 2^CNT_W-1 (31 by default) and does not wrap.
- R9: If `lin_state` changes while the line is low, the count is kept and compared with the new state's limit.
- R10: During reset and after reset the flag is 0.
- R11: The flag rises exactly one clock after the clock edge at which the tick that reaches the limit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_sync | input | 1 | Synchronised receive line (0 = dominant) |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| lin_state | input | 2 | Protocol state: 00 other, 01 sleep, 10 slave wait-break, 11 slave active |
| master_mode | input | 1 | High in master mode, which disables detection |
| rd_clr | input | 1 | Read strobe that clears the flag |
| brk_flag | output | 1 | Sticky break/wakeup detected flag |

## Verification
The count register advances on the clock edge that samples a tick. The flag register then sets on the next edge, so a detection is visible two clock edges after the tick is driven. A clear shows up one edge after `rd_clr`, and a state change takes effect one edge after the new state is applied. The bench drives every input at the falling edge. Its tick, clear and state tasks each wait two falling edges before they return, and every sample is taken at a falling edge after that, so each check reads a value that has settled. The saturation check holds the line low for 40 ticks in a disabled state and then switches to the wait-break state. A wrapped count would read 8 and would miss the limit of 11.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        LST_OTHER    = 2'b00,
        LST_SLEEP    = 2'b01,
        LST_WAIT_BRK = 2'b10,
        LST_ACTIVE   = 2'b11
    } lin_state_e;

    // Low-time limit for a given state; 0 means detection disabled.
    function automatic int unsigned limit_for(
        input lin_state_e  st,
        input logic        master,
        input int unsigned wake_bits,
        input int unsigned wait_bits,
        input int unsigned act_bits
    );
        int unsigned lim;
        lim = 0;
        if (!master) begin
            unique case (st)
                LST_SLEEP:    lim = wake_bits;
                LST_WAIT_BRK: lim = wait_bits;
                LST_ACTIVE:   lim = act_bits;
                default:      lim = 0;
            endcase
        end
        return lim;
    endfunction

endpackage

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_sync,
    input  logic             bit_tick,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || rx_sync) begin
            low_cnt <= '0;
        end else if (bit_tick && low_cnt != CNT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r6_clear_on_high: assert property (@(posedge clk) disable iff (rst)
        rx_sync |=> (low_cnt == '0));

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (low_cnt == CNT_MAX && !rx_sync) |=> (low_cnt == CNT_MAX));

endmodule

// File: rtl/lin_brk_compare.sv
module lin_brk_compare
    import lin_brk_pkg::*;
#(
    parameter int          CNT_W     = 5,
    parameter int unsigned WAKE_BITS = 4,
    parameter int unsigned WAIT_BITS = 11,
    parameter int unsigned ACT_BITS  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_sync,
    input  logic [CNT_W-1:0] low_cnt,
    input  lin_state_e       state,
    input  logic             master_mode,
    output logic             hit
);
    int unsigned limit;
    logic        fired_q;

    always_comb begin
        limit = limit_for(state, master_mode, WAKE_BITS, WAIT_BITS, ACT_BITS);
        hit   = (limit != 0) && !rx_sync && !fired_q
                && (32'(low_cnt) >= limit);
    end

    // Remembers that this low period has already produced an event.
    always_ff @(posedge clk) begin
        if (rst || rx_sync) begin
            fired_q <= 1'b0;
        end else if (hit) begin
            fired_q <= 1'b1;
        end
    end

    a_r7_once_per_low: assert property (@(posedge clk) disable iff (rst)
        (hit && !rx_sync) |=> !hit);

    a_r4_master_silent: assert property (@(posedge clk) disable iff (rst)
        master_mode |-> !hit);

endmodule

// File: rtl/lin_brk_flag.sv
module lin_brk_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd_clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (rd_clr) begin
            flag <= 1'b0;
        end
    end

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_clr) |=> flag);

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !set_evt) |=> !flag);

    a_r11_set_next: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

endmodule

// File: rtl/lin_break_detect.sv
module lin_break_detect
    import lin_brk_pkg::*;
#(
    parameter int          CNT_W     = 5,
    parameter int unsigned WAKE_BITS = 4,
    parameter int unsigned WAIT_BITS = 11,
    parameter int unsigned ACT_BITS  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_sync,
    input  logic       bit_tick,
    input  logic [1:0] lin_state,
    input  logic       master_mode,
    input  logic       rd_clr,
    output logic       brk_flag
);
    logic [CNT_W-1:0] low_cnt;
    logic             hit;
    lin_state_e       state;

    assign state = lin_state_e'(lin_state);

    lin_low_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rx_sync  (rx_sync),
        .bit_tick (bit_tick),
        .low_cnt  (low_cnt)
    );

    lin_brk_compare #(
        .CNT_W     (CNT_W),
        .WAKE_BITS (WAKE_BITS),
        .WAIT_BITS (WAIT_BITS),
        .ACT_BITS  (ACT_BITS)
    ) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .rx_sync     (rx_sync),
        .low_cnt     (low_cnt),
        .state       (state),
        .master_mode (master_mode),
        .hit         (hit)
    );

    lin_brk_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (hit),
        .rd_clr  (rd_clr),
        .flag    (brk_flag)
    );

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> !brk_flag);

    a_r4_other_silent: assert property (@(posedge clk) disable iff (rst)
        (lin_state == 2'b00 && !brk_flag && !hit) |=> !brk_flag);

endmodule

// File: tb/sim_lin_break_detect.sv
`timescale 1ns/1ps
module sim_lin_break_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_sync = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] lin_state = 2'b00;
    logic       master_mode = 1'b0;
    logic       rd_clr = 1'b0;
    logic       brk_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lin_break_detect u0 (
        .clk         (clk),
        .rst         (rst),
        .rx_sync     (rx_sync),
        .bit_tick    (bit_tick),
        .lin_state   (lin_state),
        .master_mode (master_mode),
        .rd_clr      (rd_clr),
        .brk_flag    (brk_flag)
    );

    typedef struct packed {
        logic [1:0] st;
        logic       mst;
        logic [7:0] ticks;
        logic       exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 1'b0, 8'd3,  1'b0},   // R1 below
        '{2'b01, 1'b0, 8'd4,  1'b1},   // R1 at limit
        '{2'b10, 1'b0, 8'd10, 1'b0},   // R2 below
        '{2'b10, 1'b0, 8'd11, 1'b1},   // R2 at limit
        '{2'b11, 1'b0, 8'd9,  1'b0},   // R3 below
        '{2'b11, 1'b0, 8'd10, 1'b1},   // R3 at limit
        '{2'b00, 1'b0, 8'd40, 1'b0},   // R4 other state
        '{2'b01, 1'b1, 8'd40, 1'b0},   // R4 master, sleep
        '{2'b11, 1'b1, 8'd40, 1'b0},   // R4 master, active
        '{2'b01, 1'b0, 8'd40, 1'b1}    // R1 long low
    };

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: brk_flag=%b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            step(1);
        end
    endtask

    task automatic line_high();
        @(negedge clk) rx_sync = 1'b1;
        step(2);
    endtask

    task automatic line_low();
        @(negedge clk) rx_sync = 1'b0;
        step(1);
    endtask

    task automatic clear_flag();
        @(negedge clk) rd_clr = 1'b1;
        @(negedge clk) rd_clr = 1'b0;
        step(1);
    endtask

    task automatic set_state(input logic [1:0] s);
        @(negedge clk) lin_state = s;
        step(2);
    endtask

    initial begin
        step(3);
        chk(brk_flag, 1'b0, "R10 during reset");
        @(negedge clk) rst = 1'b0;
        step(2);
        chk(brk_flag, 1'b0, "R10 after reset");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            line_high();
            clear_flag();
            lin_state   = VECS[v].st;
            master_mode = VECS[v].mst;
            line_low();
            ticks(int'(VECS[v].ticks));
            chk(brk_flag, VECS[v].exp, $sformatf("R1/R2/R3/R4 vector %0d", v));
        end
        master_mode = 1'b0;

        // R11: exact rise timing, active state
        line_high(); clear_flag();
        lin_state = 2'b11;
        line_low();
        ticks(9);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        chk(brk_flag, 1'b0, "R11 not yet after tick edge");
        step(1);
        chk(brk_flag, 1'b1, "R11 one clock later");

        // R5: sticky, then clear
        step(5);
        chk(brk_flag, 1'b1, "R5 sticky");
        clear_flag();
        chk(brk_flag, 1'b0, "R5 cleared by read");

        // R7: no second event on the same low period
        ticks(5);
        chk(brk_flag, 1'b0, "R7 same low period");
        line_high(); line_low();
        ticks(10);
        chk(brk_flag, 1'b1, "R7 new low period");

        // R6: split low periods do not add up
        line_high(); clear_flag();
        lin_state = 2'b01;
        line_low(); ticks(3);
        line_high(); line_low(); ticks(3);
        chk(brk_flag, 1'b0, "R6 count restarts");

        // R9: state change while low keeps the count
        line_high(); clear_flag();
        lin_state = 2'b10;
        line_low(); ticks(10);
        chk(brk_flag, 1'b0, "R9 below wait limit");
        set_state(2'b11);
        chk(brk_flag, 1'b1, "R9 new state limit");

        // R8: saturation, no wrap
        line_high(); clear_flag();
        lin_state = 2'b00;
        line_low(); ticks(40);
        chk(brk_flag, 1'b0, "R4 other state long low");
        set_state(2'b10);
        chk(brk_flag, 1'b1, "R8 saturated count");

        // R5: detection wins over same-cycle clear
        line_high(); clear_flag();
        lin_state = 2'b01;
        line_low(); ticks(3);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) begin bit_tick = 1'b0; rd_clr = 1'b1; end
        @(negedge clk) rd_clr = 1'b0;
        chk(brk_flag, 1'b1, "R5 set beats clear");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule